// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one asynchronous input pin and, when a chosen kind of event occurs there, copies the present count of a free-running timer into a capture register and raises a sticky interrupt flag. A 4-bit mode field, loaded through a write strobe, picks the event: a falling edge, a rising edge, or one rising edge out of every 4 or every 16. The codes that other functions use (compare, pulse-width output, and the unused codes) leave the unit idle. Code 0000 switches it off.

The pin first goes through a two-flop synchronizer. An edge detector and an event prescaler follow it. The captured value is always available on a read port. Software clears the flag with a one-cycle clear strobe. A later capture replaces an unread value. When the unit is not in a capture mode, its edge history is held low. Because of this, selecting a rising-edge mode while the pin is already high produces one capture that no real edge caused. Software should expect this and clear the flag after any mode change.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture register reads 0, the flag reads 0 and the mode is 0000 (off).
- R2: In mode 0100 a high-to-low transition of the pin causes a capture, and a low-to-high transition does not.
- R3: In mode 0101 every low-to-high transition of the pin causes a capture.
- R4: In mode 0110 only every 4th low-to-high transition causes a capture, and the three before it change neither the register nor the flag.
- R5: In mode 0111 only every 16th low-to-high transition causes a capture.
- R6: Codes 0000, 0001 to 0011 and 1000 to 1111 ignore the pin completely. Leaving mode 0000 restarts the edge count of the divided modes from zero.
- R7: A capture loads the timer value present at the capturing clock edge and sets the flag. With an input change applied before clock edge 1, the result is visible after edge 3 and not after edge 2.
- R8: Once set, the flag stays set until a clear strobe is applied, and a clear strobe with no capture resets it.
- R9: A capture made while the flag is still set overwrites the register with the new timer value.
- R10: Any write of the mode field restarts the divided edge count from zero, even when it writes the same code.
- R11: When a clear strobe and a capture fall in the same cycle, the flag ends up set.
- R12: The edge history is held low outside capture modes. Writing mode 0101 while the pin is high therefore captures at the clock edge after the write. Writing mode 0100 while the pin is high does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Loads mode_i into the mode field |
| mode_i | input | 4 | New mode code |
| pin_i | input | 1 | Asynchronous event pin |
| timer_i | input | 16 | Free-running timer count |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| capture_o | output | 16 | Capture register read port |
| flag_o | output | 1 | Sticky capture interrupt flag |

## Verification
The bench builds the unit with its defaults: a 16-bit timer, two synchronizer stages, and prescaler divisors of 4 and 16. With these values a full 16-edge cycle takes only a few hundred clocks, so the divide-by-16 boundary can be tested directly. The three-edge pin-to-flag latency can be sampled on the exact cycle on both sides. The same settings make it possible to test a mode write in the middle of a count, a clear that lands on the capture edge, and the false capture when the unit leaves the off mode.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] M_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] M_FALL   = 4'b0100;
    localparam logic [MODE_W-1:0] M_RISE   = 4'b0101;
    localparam logic [MODE_W-1:0] M_RISE_A = 4'b0110;
    localparam logic [MODE_W-1:0] M_RISE_B = 4'b0111;

    typedef enum logic [1:0] {
        DIV_ONE = 2'd0,
        DIV_A   = 2'd1,
        DIV_B   = 2'd2
    } div_e;

    function automatic logic is_capture(input logic [MODE_W-1:0] m);
        return (m[3:2] == 2'b01);
    endfunction

    function automatic div_e div_of(input logic [MODE_W-1:0] m);
        if (m == M_RISE_A) return DIV_A;
        if (m == M_RISE_B) return DIV_B;
        return DIV_ONE;
    endfunction

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    // History follows the level only while armed; otherwise it is held low.
    always_comb begin
        prev_d = arm_i ? lvl_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

    // R12: history is low one cycle after a disarmed cycle
    p_hist_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !prev_q);
endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale #(
    parameter int LOG_A = 2,
    parameter int LOG_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  tcap_pkg::div_e    sel_i,
    input  logic              ev_i,
    output logic              fire_o
);
    import tcap_pkg::*;

    localparam int CNT_W = (LOG_B > LOG_A) ? LOG_B : LOG_A;
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'((1 << LOG_A) - 1);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'((1 << LOG_B) - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    always_comb begin
        unique case (sel_i)
            DIV_A:   last_cnt = LAST_A;
            DIV_B:   last_cnt = LAST_B;
            default: last_cnt = '0;
        endcase
        at_last = (cnt_q == last_cnt);
        fire_o  = ev_i && at_last;
        cnt_d   = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (ev_i) cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: a clear leaves the count at zero
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    // R4: the count never runs past the selected divisor
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= last_cnt));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit #(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LOG_A       = 2,
    parameter int LOG_B       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_i,
    input  logic [3:0]    mode_i,
    input  logic          pin_i,
    input  logic [TW-1:0] timer_i,
    input  logic          flag_clr_i,
    output logic [TW-1:0] capture_o,
    output logic          flag_o
);
    import tcap_pkg::*;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [TW-1:0]     cap;
        logic              flag;
    } state_t;

    state_t st_d, st_q;

    logic lvl, rise, fall, armed, ev, hit, pre_clr;
    div_e div_sel;

    tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl)
    );

    tcap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .arm_i(armed), .lvl_i(lvl),
        .rise_o(rise), .fall_o(fall)
    );

    tcap_prescale #(.LOG_A(LOG_A), .LOG_B(LOG_B)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(pre_clr), .sel_i(div_sel),
        .ev_i(ev), .fire_o(hit)
    );

    always_comb begin
        armed   = is_capture(st_q.mode);
        div_sel = div_of(st_q.mode);
        pre_clr = mode_wr_i || (st_q.mode == M_OFF);
        if (!armed)                   ev = 1'b0;
        else if (st_q.mode == M_FALL) ev = fall;
        else                          ev = rise;

        st_d = st_q;
        if (mode_wr_i)       st_d.mode = mode_i;
        if (hit)             st_d.cap  = timer_i;
        if (hit)             st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_OFF, cap: '0, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign capture_o = st_q.cap;
    assign flag_o    = st_q.flag;

    // R7: a prescaler hit loads the timer and raises the flag
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (flag_o && capture_o == $past(timer_i)));
    // R8: flag holds without a clear
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);
    // R8: a clear with no hit drops the flag
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !hit) |=> !flag_o);
    // R11: a hit wins over a simultaneous clear
    p_clr_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && hit) |=> flag_o);
    // R6: non-capture codes never produce a hit
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(st_q.mode) |-> !hit);
    // R9: the register changes only on a hit
    p_cap_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(capture_o));
endmodule

// File: tb/tcap_unit_bench.sv
`timescale 1ns/1ps
module tcap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr_i = 1'b0;
    logic [3:0]  mode_i = 4'b0000;
    logic        pin_i = 1'b0;
    logic [15:0] timer_i = '0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] capture_o;
    logic        flag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] val;
        logic        flag;
        string       req;
    } exp_t;
    exp_t sb_q[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    tcap_unit u_tcap_unit (
        .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
        .pin_i(pin_i), .timer_i(timer_i), .flag_clr_i(flag_clr_i),
        .capture_o(capture_o), .flag_o(flag_o)
    );

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (capture_o !== e.val || flag_o !== e.flag) begin
                    fails++;
                    $display("FAIL %s: capture=%h flag=%b expected capture=%h flag=%b",
                             e.req, capture_o, flag_o, e.val, e.flag);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(input logic [15:0] v, input logic f, input string r);
        exp_t e;
        e.val = v; e.flag = f; e.req = r;
        sb_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode_i = m; mode_wr_i = 1'b1;
        step(1);
        mode_wr_i = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] t);
        timer_i = t;
        pin_i = 1'b1; step(4);
        pin_i = 1'b0; step(4);
    endtask

    initial begin
        step(3);
        expect_st(16'h0000, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        step(1);

        // R6: off and non-capture codes ignore the pin
        pulse(16'h1111);
        expect_st(16'h0000, 1'b0, "R6 mode 0000");
        set_mode(4'b0001); pulse(16'h2222);
        expect_st(16'h0000, 1'b0, "R6 mode 0001");
        set_mode(4'b1000); pulse(16'h3333);
        expect_st(16'h0000, 1'b0, "R6 mode 1000");
        set_mode(4'b1101); pulse(16'h3334);
        expect_st(16'h0000, 1'b0, "R6 mode 1101");

        // R3: rising edge capture
        set_mode(4'b0101);
        pulse(16'h1234);
        expect_st(16'h1234, 1'b1, "R3 rising capture");

        // R8: sticky flag, then clear
        step(6);
        expect_st(16'h1234, 1'b1, "R8 flag sticky");
        clear_flag();
        expect_st(16'h1234, 1'b0, "R8 flag cleared");

        // R9: overwrite of an unread value
        pulse(16'hA5A5);
        pulse(16'h5A5A);
        expect_st(16'h5A5A, 1'b1, "R9 overwrite");
        clear_flag();

        // R7: latency of three edges
        timer_i = 16'hBEEF;
        pin_i = 1'b1;
        step(2);
        expect_st(16'h5A5A, 1'b0, "R7 not yet after edge 2");
        step(1);
        expect_st(16'hBEEF, 1'b1, "R7 visible after edge 3");
        pin_i = 1'b0; step(4);
        clear_flag();

        // R2: falling edge mode
        set_mode(4'b0100);
        timer_i = 16'h0F0F;
        pin_i = 1'b1; step(4);
        expect_st(16'hBEEF, 1'b0, "R2 rising ignored");
        pin_i = 1'b0; step(4);
        expect_st(16'h0F0F, 1'b1, "R2 falling capture");
        clear_flag();

        // R4: every 4th rising edge
        set_mode(4'b0110);
        for (int i = 0; i < 3; i++) pulse(16'h4400 + 16'(i));
        expect_st(16'h0F0F, 1'b0, "R4 three edges no capture");
        pulse(16'h4444);
        expect_st(16'h4444, 1'b1, "R4 fourth edge capture");
        clear_flag();

        // R10: a mode write restarts the count
        pulse(16'h7000); pulse(16'h7001);
        set_mode(4'b0110);
        for (int i = 0; i < 3; i++) pulse(16'h7100 + 16'(i));
        expect_st(16'h4444, 1'b0, "R10 count restarted");
        pulse(16'h7777);
        expect_st(16'h7777, 1'b1, "R10 capture after restart");
        clear_flag();

        // R6: leaving off restarts the count
        set_mode(4'b0110);
        pulse(16'h6000); pulse(16'h6001);
        set_mode(4'b0000);
        pulse(16'h6002); pulse(16'h6003);
        set_mode(4'b0110);
        for (int i = 0; i < 3; i++) pulse(16'h6100 + 16'(i));
        expect_st(16'h7777, 1'b0, "R6 off then three edges");
        pulse(16'h6666);
        expect_st(16'h6666, 1'b1, "R6 capture after off");
        clear_flag();

        // R5: every 16th rising edge
        set_mode(4'b0111);
        for (int i = 0; i < 15; i++) pulse(16'h1600 + 16'(i));
        expect_st(16'h6666, 1'b0, "R5 fifteen edges no capture");
        pulse(16'h1616);
        expect_st(16'h1616, 1'b1, "R5 sixteenth edge capture");
        clear_flag();

        // R11: clear and capture in the same cycle
        set_mode(4'b0101);
        pulse(16'h0101);
        timer_i = 16'hC0DE;
        pin_i = 1'b1;
        step(2);
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
        expect_st(16'hC0DE, 1'b1, "R11 capture wins over clear");
        pin_i = 1'b0; step(4);
        clear_flag();

        // R12: false capture on entering rising mode with pin high
        set_mode(4'b0000);
        pin_i = 1'b1; step(4);
        timer_i = 16'hFA15;
        set_mode(4'b0101);
        step(1);
        expect_st(16'hFA15, 1'b1, "R12 false capture on mode entry");
        clear_flag();
        step(4);
        expect_st(16'hFA15, 1'b0, "R12 only one false capture");
        set_mode(4'b0000);
        step(2);
        timer_i = 16'hDEAD;
        set_mode(4'b0100);
        step(3);
        expect_st(16'hFA15, 1'b0, "R12 falling mode entry no capture");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule